// File: doc/BRIEF.md
# Receive DMA Fly-By Request Controller

This block sits between a network receive buffer and an external 16-bit DMA channel running in fly-by fashion: the DMA controller drives the system memory write while the block supplies data on the I/O read strobe, so each word crosses the bus once. The block keeps a count of received frames that are complete and stored, together with their byte lengths. While that count is non-zero and DMA reception is enabled, it raises a request line.

When the channel answers with acknowledge and address-enable both high, every rising edge of the I/O read strobe moves one 16-bit word from the buffer's frame-read port to the data output. No address decode takes part in this. A burst control bit decides whether the request drops after every word or stays high until the frame's last word. After the last word the frame is retired and the request is evaluated again for the next stored frame.

Top module: `rxdma_flyby_ctrl`

## Requirements
- R1: After a synchronous reset, `drq`, `dma_data`, `fb_rd_addr`, `fb_rd_en` and `fb_frame_done` are all zero.
- R2: DMA reception is enabled when `cfg_dma_only` or `cfg_dma_auto` is 1, and either bit alone is enough. With both at 0, `drq` stays 0 and read strobes move no data (`fb_rd_en` stays 0 and `fb_rd_addr` holds).
- R3: A one-cycle `frm_done` pulse, sampled while reception is enabled and no word cycle is in progress, makes `drq` read 1 after that same clock edge.
- R4: A word transfer happens only on a rising edge of `ior` (a 0 sample followed by a 1 sample) while `dmack` and `aen` are both 1. An `ior` held high for several cycles moves exactly one word.
- R5: On a transfer edge, `dma_data` takes the value of `fb_rd_data` as seen at the current `fb_rd_addr`. `fb_rd_en` is 1 for exactly the one cycle after that edge, and `fb_rd_addr` counts words 0, 1, 2 … within the frame.
- R6: A frame of L bytes takes ceil(L/2) words. `fb_frame_done` is 1 in the same cycle as `fb_rd_en` for the last word, and `fb_rd_addr` then returns to 0.
- R7: With `cfg_burst` at 0, `drq` is 0 in the cycle after each word transfer. It returns to 1 the cycle after `ior` is first sampled low, provided a frame is still pending.
- R8: With `cfg_burst` at 1, `drq` stays 1 after every word of a frame except the last. After the last word it is 0, and it is evaluated again once `ior` is sampled low.
- R9: `drq` remains asserted between word cycles while at least one complete frame is stored, and is 0 once no frame is pending.
- R10: The pending-frame count saturates at `DEPTH`. A completion arriving while full, with no frame finishing in the same cycle, is discarded together with its length.
- R11: A completion in the same cycle as a frame's last word leaves the pending count unchanged, and the new frame's length is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dma_only | input | 1 | Receive-by-DMA-only enable |
| cfg_dma_auto | input | 1 | Automatic receive DMA enable |
| cfg_burst | input | 1 | 1: hold request for whole frame; 0: drop per word |
| frm_done | input | 1 | One-cycle pulse: a frame is fully stored |
| frm_len | input | LEN_W | Byte length of the frame announced by `frm_done` |
| dmack | input | 1 | DMA acknowledge from the channel |
| aen | input | 1 | Address enable driven by the DMA controller |
| ior | input | 1 | I/O read strobe, synchronous to `clk` |
| fb_rd_data | input | DATA_W | Word at `fb_rd_addr` of the head frame |
| drq | output | 1 | DMA request |
| dma_data | output | DATA_W | Registered word presented to the bus |
| fb_rd_addr | output | LEN_W | Word index within the head frame |
| fb_rd_en | output | 1 | One-cycle pulse: a word was consumed |
| fb_frame_done | output | 1 | One-cycle pulse: head frame fully transferred |

## Verification
The bench goes after the edges of the request line. A design that forgot to drop `drq` per word in non-burst mode, or dropped it mid-frame in burst mode, would show the wrong level right after a strobe. A strobe held high is checked to move exactly one word, and strobes without acknowledge or address-enable are checked to move none; a level-sensitive or under-qualified design would skip frame words or corrupt data. Odd byte lengths check the round-up, so a truncating word count ends frames one word early. A fifth frame while four are pending, and a completion landing on the last-word edge, catch a counter that wraps or loses the simultaneous event, which would show up as a stuck-high or missing request.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  typedef struct packed {
    logic only_dma;
    logic auto_dma;
    logic burst;
  } rxdma_cfg_t;

  function automatic logic rx_dma_on(input rxdma_cfg_t c);
    return c.only_dma | c.auto_dma;
  endfunction

endpackage

// File: rtl/rxdma_len_fifo.sv
module rxdma_len_fifo #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [LEN_W-1:0] head_len,
  output logic             pend_nz,
  output logic             pend_nz_next
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  logic [LEN_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt, cnt_next;
  logic             full, accept, take;

  assign full   = (cnt == FULL_C);
  assign take   = pop && (cnt != '0);
  assign accept = push && (!full || take);

  always_comb begin
    cnt_next = cnt;
    case ({accept, take})
      2'b10:   cnt_next = cnt + 1'b1;
      2'b01:   cnt_next = cnt - 1'b1;
      default: cnt_next = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      cnt <= cnt_next;
      if (accept) wptr <= (wptr == LAST_P) ? '0 : wptr + 1'b1;
      if (take)   rptr <= (rptr == LAST_P) ? '0 : rptr + 1'b1;
    end
  end

  assign head_len     = mem[rptr];
  assign pend_nz      = (cnt != '0);
  assign pend_nz_next = (cnt_next != '0);

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= FULL_C);

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |=> (cnt == FULL_C));

  // R11
  swap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && pop && cnt != '0) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/rxdma_word_seq.sv
module rxdma_word_seq #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              pend_nz,
  input  logic              dmack,
  input  logic              aen,
  input  logic              ior,
  input  logic [LEN_W-1:0]  head_len,
  input  logic [DATA_W-1:0] fb_rd_data,
  output logic              word_fire,
  output logic              last_word,
  output logic [LEN_W-1:0]  fb_rd_addr,
  output logic              fb_rd_en,
  output logic              fb_frame_done,
  output logic [DATA_W-1:0] dma_data
);
  localparam logic [LEN_W:0] ONE_C = {{LEN_W{1'b0}}, 1'b1};

  logic           ior_q;
  logic [LEN_W:0] n_words, idx_p1;

  assign n_words   = ({1'b0, head_len} + ONE_C) >> 1;
  assign idx_p1    = {1'b0, fb_rd_addr} + ONE_C;
  assign last_word = (idx_p1 >= n_words);
  assign word_fire = ior && !ior_q && dmack && aen && en && pend_nz;

  always_ff @(posedge clk) begin
    if (rst) begin
      ior_q         <= 1'b0;
      fb_rd_addr    <= '0;
      fb_rd_en      <= 1'b0;
      fb_frame_done <= 1'b0;
      dma_data      <= '0;
    end else begin
      ior_q         <= ior;
      fb_rd_en      <= word_fire;
      fb_frame_done <= word_fire && last_word;
      if (word_fire) begin
        dma_data   <= fb_rd_data;
        fb_rd_addr <= last_word ? '0 : idx_p1[LEN_W-1:0];
      end
    end
  end

  // R4
  qual_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!dmack || !aen) |=> !fb_rd_en);

  // R6
  done_with_word_chk: assert property (@(posedge clk) disable iff (rst)
    fb_frame_done |-> fb_rd_en);

  // R4
  single_word_chk: assert property (@(posedge clk) disable iff (rst)
    fb_rd_en |=> !fb_rd_en);

endmodule

// File: rtl/rxdma_req_gen.sv
module rxdma_req_gen (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic burst,
  input  logic ior,
  input  logic word_fire,
  input  logic last_word,
  input  logic pend_nz_next,
  output logic drq
);
  logic pause, pause_next;

  always_comb begin
    if (word_fire) pause_next = last_word || !burst;
    else           pause_next = pause && ior;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pause <= 1'b0;
      drq   <= 1'b0;
    end else begin
      pause <= pause_next;
      drq   <= en && pend_nz_next && !pause_next;
    end
  end

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst) !en |=> !drq);

  // R7
  burst_clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (word_fire && !burst) |=> !drq);

  // R8
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (word_fire && burst && !last_word) |=> drq);

endmodule

// File: rtl/rxdma_flyby_ctrl.sv
module rxdma_flyby_ctrl #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 11,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_dma_only,
  input  logic              cfg_dma_auto,
  input  logic              cfg_burst,
  input  logic              frm_done,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              dmack,
  input  logic              aen,
  input  logic              ior,
  input  logic [DATA_W-1:0] fb_rd_data,
  output logic              drq,
  output logic [DATA_W-1:0] dma_data,
  output logic [LEN_W-1:0]  fb_rd_addr,
  output logic              fb_rd_en,
  output logic              fb_frame_done
);
  import rxdma_pkg::*;

  rxdma_cfg_t       cfg;
  logic             en;
  logic             pend_nz, pend_nz_next;
  logic [LEN_W-1:0] head_len;
  logic             word_fire, last_word;

  assign cfg = '{only_dma: cfg_dma_only, auto_dma: cfg_dma_auto, burst: cfg_burst};
  assign en  = rx_dma_on(cfg);

  rxdma_len_fifo #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_fifo (
    .clk          (clk),
    .rst          (rst),
    .push         (frm_done),
    .push_len     (frm_len),
    .pop          (word_fire && last_word),
    .head_len     (head_len),
    .pend_nz      (pend_nz),
    .pend_nz_next (pend_nz_next)
  );

  rxdma_word_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .pend_nz       (pend_nz),
    .dmack         (dmack),
    .aen           (aen),
    .ior           (ior),
    .head_len      (head_len),
    .fb_rd_data    (fb_rd_data),
    .word_fire     (word_fire),
    .last_word     (last_word),
    .fb_rd_addr    (fb_rd_addr),
    .fb_rd_en      (fb_rd_en),
    .fb_frame_done (fb_frame_done),
    .dma_data      (dma_data)
  );

  rxdma_req_gen u_req (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .burst        (cfg.burst),
    .ior          (ior),
    .word_fire    (word_fire),
    .last_word    (last_word),
    .pend_nz_next (pend_nz_next),
    .drq          (drq)
  );

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend_nz && !frm_done) |=> !drq);

endmodule

// File: tb/tb_rxdma_flyby_ctrl.sv
`timescale 1ns/1ps
module tb_rxdma_flyby_ctrl;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 11;
  localparam int DEPTH  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_dma_only = 1'b0, cfg_dma_auto = 1'b0, cfg_burst = 1'b0;
  logic frm_done = 1'b0;
  logic [LEN_W-1:0] frm_len = '0;
  logic dmack = 1'b0, aen = 1'b0, ior = 1'b0;
  logic [DATA_W-1:0] fb_rd_data;
  logic drq, fb_rd_en, fb_frame_done;
  logic [DATA_W-1:0] dma_data;
  logic [LEN_W-1:0] fb_rd_addr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done_flag = 0;
  logic [3:0] head_tag;
  logic [3:0] exp_tag = 4'd0;

  always #2.5 clk = ~clk;

  rxdma_flyby_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .cfg_dma_only(cfg_dma_only), .cfg_dma_auto(cfg_dma_auto),
    .cfg_burst(cfg_burst), .frm_done(frm_done), .frm_len(frm_len), .dmack(dmack),
    .aen(aen), .ior(ior), .fb_rd_data(fb_rd_data), .drq(drq), .dma_data(dma_data),
    .fb_rd_addr(fb_rd_addr), .fb_rd_en(fb_rd_en), .fb_frame_done(fb_frame_done)
  );

  // buffer model: head frame advances when the block releases it
  always @(posedge clk) begin
    if (rst) head_tag <= 4'd0;
    else if (fb_frame_done) head_tag <= head_tag + 4'd1;
  end
  assign fb_rd_data = {4'hA, head_tag, fb_rd_addr[7:0]};

  function automatic logic [15:0] word_val(input logic [3:0] tag, input int idx);
    return {4'hA, tag, 8'(idx)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int len);
    @(negedge clk);
    frm_done = 1'b1;
    frm_len  = LEN_W'(len);
    @(negedge clk);
    frm_done = 1'b0;
  endtask

  task automatic do_word(input int idx, input bit last, input bit exp_drq, input bit exp_after);
    @(negedge clk);
    ior = 1'b1;
    @(negedge clk);
    chk("R5 data", dma_data, word_val(exp_tag, idx));
    chk("R5 rd_en", fb_rd_en, 1);
    chk(cfg_burst ? "R8 drq in word" : "R7 drq in word", drq, exp_drq);
    chk("R6 frame_done", fb_frame_done, last);
    ior = 1'b0;
    @(negedge clk);
    chk("R9 drq after word", drq, exp_after);
    if (last) exp_tag = exp_tag + 4'd1;
  endtask

  // {burst, byte length}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 11'd1}, {1'b0, 11'd2}, {1'b0, 11'd5},
    {1'b1, 11'd6}, {1'b1, 11'd7}, {1'b1, 11'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 drq", drq, 0);
    chk("R1 dma_data", dma_data, 0);
    chk("R1 addr", fb_rd_addr, 0);
    chk("R1 rd_en", fb_rd_en, 0);
    chk("R1 frame_done", fb_frame_done, 0);

    cfg_dma_only = 1'b1;
    dmack = 1'b1;
    aen = 1'b1;
    for (int v = 0; v < 6; v++) begin
      int len;
      int nw;
      cfg_burst = VEC[v][11];
      len = int'(VEC[v][10:0]);
      nw = (len + 1) / 2;
      push(len);
      chk("R3 drq after completion", drq, 1);
      for (int w = 0; w < nw; w++) begin
        bit last;
        last = (w == nw - 1);
        do_word(w, last, (!last && cfg_burst), !last);
      end
      chk("R6 addr back to 0", fb_rd_addr, 0);
    end

    // R4: strobes without both qualifiers move nothing; held strobe moves one word
    cfg_burst = 1'b0;
    push(6);
    dmack = 1'b0;
    @(negedge clk); ior = 1'b1;
    @(negedge clk); chk("R4 no dmack rd_en", fb_rd_en, 0); ior = 1'b0;
    dmack = 1'b1; aen = 1'b0;
    @(negedge clk); ior = 1'b1;
    @(negedge clk); chk("R4 no aen rd_en", fb_rd_en, 0); ior = 1'b0;
    aen = 1'b1;
    @(negedge clk);
    chk("R4 addr held", fb_rd_addr, 0);
    chk("R9 drq pending", drq, 1);
    do_word(0, 0, 0, 1);
    @(negedge clk); ior = 1'b1;
    @(negedge clk); chk("R4 held first", fb_rd_en, 1);
    @(negedge clk); chk("R4 held no second", fb_rd_en, 0);
    chk("R4 held addr", fb_rd_addr, 2);
    chk("R7 drq while held", drq, 0);
    ior = 1'b0;
    @(negedge clk);
    chk("R7 drq back", drq, 1);
    do_word(2, 1, 0, 0);

    // R2: both enables off, then the other bit alone
    cfg_dma_only = 1'b0;
    push(2);
    @(negedge clk);
    chk("R2 drq off", drq, 0);
    ior = 1'b1;
    @(negedge clk);
    chk("R2 rd_en off", fb_rd_en, 0);
    ior = 1'b0;
    @(negedge clk);
    chk("R2 addr off", fb_rd_addr, 0);
    cfg_dma_auto = 1'b1;
    @(negedge clk);
    chk("R2 auto bit enables", drq, 1);
    do_word(0, 1, 0, 0);

    // R11: completion on the last-word edge
    push(2);
    @(negedge clk);
    ior = 1'b1; frm_done = 1'b1; frm_len = LEN_W'(4);
    @(negedge clk);
    frm_done = 1'b0;
    chk("R11 word", dma_data, word_val(exp_tag, 0));
    chk("R11 frame_done", fb_frame_done, 1);
    exp_tag = exp_tag + 4'd1;
    ior = 1'b0;
    @(negedge clk);
    chk("R11 drq kept", drq, 1);
    do_word(0, 0, 0, 1);
    do_word(1, 1, 0, 0);

    // R10: saturation discards the fifth frame
    for (int k = 0; k < DEPTH + 1; k++) push((k == DEPTH) ? 8 : 2);
    for (int k = 0; k < DEPTH; k++) do_word(0, 1, 0, (k != DEPTH - 1));
    chk("R10 extra dropped", drq, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule